// File: doc/BRIEF.md
# Twin-Mask Vector Element Stepper

This block walks the element positions of one vector operation whose inputs and outputs are filtered by two separate predicate masks. On a start pulse it captures a vector length, a predicate mode, the candidate mask sources and two inversion flags. It then produces a stream of (source element, destination element) index pairs. Each pair names one element operation that the surrounding pipeline must carry out.

The source counter steps only over set bits of the source mask, and the destination counter steps only over set bits of the destination mask. The two counters move independently, so the stream pairs the k-th selected source element with the k-th selected destination element. This makes a compacting read on one side feed an expanding write on the other. The loop finishes as soon as either side has no selected element left below the vector length. Both counters stay visible at all times, so the surrounding logic can save them as part of its vector state and later resume from them.

Register file access and the element operation itself belong to the surrounding pipeline.

Top module: `tps_stepper`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are 0, and both `src_step` and `dst_step` are 0.
- R2: The `src_step` values offered with `out_valid` are exactly the set bits of the source mask below the effective length, offered in ascending order, and no set bit is skipped.
- R3: The `dst_step` values offered with `out_valid` are exactly the set bits of the destination mask below the effective length, in ascending order. The destination side skips its clear bits independently of the source side.
- R4: `pred_mode` 2'b01 (integer) takes mask bit i from bit i of `dst_reg` for the destination. The source mask also comes from `dst_reg` unless `twin` is 1, in which case it comes from `src_reg`.
- R5: `pred_mode` 2'b10 (condition) takes mask bit i from bit i of `dst_cond` for the destination. The source mask also comes from `dst_cond` unless `twin` is 1, in which case it comes from `src_cond`.
- R6: In integer and condition modes, `src_inv` = 1 complements the source mask and `dst_inv` = 1 complements the destination mask, each on its own. Example: length 2, both registers 2'b10, `twin` = 1, `src_inv` = 1, `dst_inv` = 0 gives the single pair (0, 1).
- R7: `pred_mode` 2'b00 or 2'b11 uses all-ones masks and ignores the inversion flags, so the pairs (0,0), (1,1), ... up to length-1 are issued in order.
- R8: The number of pairs issued equals the smaller of the two mask population counts below the effective length. After the last pair, `done` rises with `busy` low and `out_valid` low, and stays high until the next accepted start.
- R9: With length 0, or with either mask empty below the length, no pair is issued. `done` is then high at the second rising edge after the one that samples `start`.
- R10: While `out_valid` is 1 and `out_ready` is 0, the pair and `out_valid` hold unchanged into the next cycle.
- R11: After the n-th accepted pair, each counter shows the position of its next set mask bit, or the effective length if none is left. The final `src_step` and `dst_step` therefore show the first unused position of each side.
- R12: A `start` pulse is accepted only when `busy` is 0. A `start` that arrives while busy neither restarts nor alters the running sequence.
- R13: The effective length is `vl` clamped to ELEMS (64 by default). A length of 100 in all-ones mode issues 64 pairs and ends with both counters at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new sequence (accepted only when not busy) |
| vl | input | VLW (7) | Vector length |
| pred_mode | input | 2 | 00/11 all-ones, 01 integer register, 10 per-element condition bits |
| twin | input | 1 | Source mask uses its own selector |
| src_inv | input | 1 | Complement the source mask |
| dst_inv | input | 1 | Complement the destination mask |
| src_reg | input | ELEMS (64) | Integer register value for the source selector |
| dst_reg | input | ELEMS (64) | Integer register value for the destination selector |
| src_cond | input | ELEMS (64) | Per-element condition bits, source selector |
| dst_cond | input | ELEMS (64) | Per-element condition bits, destination selector |
| out_valid | output | 1 | An index pair is offered |
| out_ready | input | 1 | Consumer takes the offered pair |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished |
| src_step | output | VLW (7) | Source counter / source element index |
| dst_step | output | VLW (7) | Destination counter / destination element index |

## Verification
The delicate cycle is the one in which a pair is accepted and, on the same edge, the rescan on one side finds nothing more below the length. The consumer must then see no extra pair, and completion must follow. The exhaustive sweep over 4-bit masks and lengths 0 to 4 gives unequal source and destination counts on either side, under a pseudo-random ready pattern. Each run is judged by the count of pairs, by the exact pair indices, and by the final counter values. A second collision, a start arriving during a stalled run, is provoked with a changed length and judged by the sequence finishing unchanged.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INT  = 2'd1,
    PM_CR   = 2'd2,
    PM_RSVD = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;
endpackage

// File: rtl/tps_mask_former.sv
module tps_mask_former #(
  parameter int ELEMS = 64,
  parameter int VLW   = 7
) (
  input  logic [1:0]       mode,
  input  logic             twin,
  input  logic             src_inv,
  input  logic             dst_inv,
  input  logic [ELEMS-1:0] src_reg,
  input  logic [ELEMS-1:0] dst_reg,
  input  logic [ELEMS-1:0] src_cond,
  input  logic [ELEMS-1:0] dst_cond,
  input  logic [VLW-1:0]   lim,
  output logic [ELEMS-1:0] src_mask,
  output logic [ELEMS-1:0] dst_mask
);
  import tps_pkg::*;

  // side 0 = source, side 1 = destination
  logic [ELEMS-1:0] reg_pick  [2];
  logic [ELEMS-1:0] cond_pick [2];
  logic             inv_pick  [2];
  logic [ELEMS-1:0] shaped    [2];
  logic [ELEMS-1:0] window;

  function automatic logic [ELEMS-1:0] below(input logic [VLW-1:0] n);
    logic [ELEMS-1:0] w;
    for (int i = 0; i < ELEMS; i++) w[i] = (i < int'(n));
    return w;
  endfunction

  assign window       = below(lim);
  assign reg_pick[0]  = twin ? src_reg  : dst_reg;
  assign reg_pick[1]  = dst_reg;
  assign cond_pick[0] = twin ? src_cond : dst_cond;
  assign cond_pick[1] = dst_cond;
  assign inv_pick[0]  = src_inv;
  assign inv_pick[1]  = dst_inv;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [ELEMS-1:0] raw;
    always_comb begin
      case (mode)
        PM_INT:  raw = inv_pick[s] ? ~reg_pick[s]  : reg_pick[s];
        PM_CR:   raw = inv_pick[s] ? ~cond_pick[s] : cond_pick[s];
        default: raw = '1;
      endcase
      shaped[s] = raw & window;
    end
  end

  assign src_mask = shaped[0];
  assign dst_mask = shaped[1];
endmodule

// File: rtl/tps_step_lane.sv
module tps_step_lane #(
  parameter int ELEMS = 64,
  parameter int VLW   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [ELEMS-1:0] mask_in,
  input  logic [VLW-1:0]   lim,
  output logic [VLW-1:0]   step,
  output logic             live
);
  localparam int IDXW = (ELEMS > 1) ? $clog2(ELEMS) : 1;

  logic [ELEMS-1:0] mask_q;
  logic [VLW-1:0]   lim_q;
  logic [VLW-1:0]   first_hit;
  logic [VLW-1:0]   next_hit;

  // lowest set bit at or above 'from' and below 'stop'; 'stop' if none
  function automatic logic [VLW-1:0] scan_up(input logic [ELEMS-1:0] m,
                                             input logic [VLW:0]     from,
                                             input logic [VLW-1:0]   stop);
    logic [VLW-1:0] hit;
    logic           found;
    hit   = stop;
    found = 1'b0;
    for (int i = 0; i < ELEMS; i++) begin
      if (!found && m[i] && i >= int'(from) && i < int'(stop)) begin
        hit   = VLW'(i);
        found = 1'b1;
      end
    end
    return hit;
  endfunction

  assign first_hit = scan_up(mask_in, '0, lim);
  assign next_hit  = scan_up(mask_q, {1'b0, step} + 1'b1, lim_q);
  assign live      = step < lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      lim_q  <= '0;
      step   <= '0;
    end else if (load) begin
      mask_q <= mask_in;
      lim_q  <= lim;
      step   <= first_hit;
    end else if (advance && live) begin
      step <= next_hit;
    end
  end

  // R2: a live counter always rests on a selected element
  a_r2_on_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> mask_q[step[IDXW-1:0]]);

  // R2: each accepted step moves strictly upward
  a_r2_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && live && !load) |=> step > $past(step));

  // R11: without load or advance the saved counter does not move
  a_r11_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(step));
endmodule

// File: rtl/tps_stepper.sv
module tps_stepper #(
  parameter int ELEMS = 64,
  parameter int VLW   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [1:0]       pred_mode,
  input  logic             twin,
  input  logic             src_inv,
  input  logic             dst_inv,
  input  logic [ELEMS-1:0] src_reg,
  input  logic [ELEMS-1:0] dst_reg,
  input  logic [ELEMS-1:0] src_cond,
  input  logic [ELEMS-1:0] dst_cond,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic [VLW-1:0]   src_step,
  output logic [VLW-1:0]   dst_step
);
  import tps_pkg::*;

  phase_e           phase;
  logic [VLW-1:0]   vl_eff;
  logic [ELEMS-1:0] src_mask;
  logic [ELEMS-1:0] dst_mask;
  logic             src_live;
  logic             dst_live;

  // named events
  logic start_take;
  logic fire;
  logic exhaust;

  function automatic logic [VLW-1:0] clamp_len(input logic [VLW-1:0] v);
    return (int'(v) > ELEMS) ? VLW'(ELEMS) : v;
  endfunction

  assign vl_eff     = clamp_len(vl);
  assign start_take = start && (phase != PH_RUN);
  assign out_valid  = (phase == PH_RUN) && src_live && dst_live;
  assign fire       = out_valid && out_ready;
  assign exhaust    = (phase == PH_RUN) && !(src_live && dst_live);
  assign busy       = (phase == PH_RUN);
  assign done       = (phase == PH_FIN);

  tps_mask_former #(.ELEMS(ELEMS), .VLW(VLW)) u_masks (
    .mode     (pred_mode),
    .twin     (twin),
    .src_inv  (src_inv),
    .dst_inv  (dst_inv),
    .src_reg  (src_reg),
    .dst_reg  (dst_reg),
    .src_cond (src_cond),
    .dst_cond (dst_cond),
    .lim      (vl_eff),
    .src_mask (src_mask),
    .dst_mask (dst_mask)
  );

  tps_step_lane #(.ELEMS(ELEMS), .VLW(VLW)) u_src_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_take),
    .advance (fire),
    .mask_in (src_mask),
    .lim     (vl_eff),
    .step    (src_step),
    .live    (src_live)
  );

  tps_step_lane #(.ELEMS(ELEMS), .VLW(VLW)) u_dst_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_take),
    .advance (fire),
    .mask_in (dst_mask),
    .lim     (vl_eff),
    .step    (dst_step),
    .live    (dst_live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_RUN:  if (exhaust) phase <= PH_FIN;
        default: if (start_take) phase <= PH_RUN;
      endcase
    end
  end

  // R10: a stalled pair is held unchanged
  a_r10_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_step) && $stable(dst_step)));

  // R8: completion is exclusive of running and of offering a pair
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !busy));

  // R12: a running sequence is not cut short while both sides remain live
  a_r12_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exhaust) |=> busy);

  // R9: once a side runs out, completion follows on the next cycle
  a_r9_exhaust_finish: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust |=> done);
endmodule

// File: tb/tps_stepper_test.sv
`timescale 1ns/1ps
module tps_stepper_test;
  localparam int EL = 64;
  localparam int VW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] vl = '0;
  logic [1:0]    pmode = 2'b00;
  logic          twin = 1'b0, sinv = 1'b0, dinv = 1'b0;
  logic [EL-1:0] sreg = '0, dreg = '0, scond = '0, dcond = '0;
  logic          out_ready = 1'b0;
  logic          out_valid, busy, done;
  logic [VW-1:0] src_step, dst_step;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  tps_stepper #(.ELEMS(EL), .VLW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred_mode(pmode),
    .twin(twin), .src_inv(sinv), .dst_inv(dinv),
    .src_reg(sreg), .dst_reg(dreg), .src_cond(scond), .dst_cond(dcond),
    .out_valid(out_valid), .out_ready(out_ready), .busy(busy), .done(done),
    .src_step(src_step), .dst_step(dst_step)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected mask from the requirements (R4..R7, R13)
  function automatic logic [63:0] model_mask(input int mode, input bit inv,
                                             input logic [63:0] r, input logic [63:0] c,
                                             input int len);
    logic [63:0] m;
    if (mode == 1)      m = inv ? ~r : r;
    else if (mode == 2) m = inv ? ~c : c;
    else                m = '1;
    for (int i = 0; i < 64; i++) if (i >= len) m[i] = 1'b0;
    return m;
  endfunction

  function automatic int kth(input logic [63:0] m, input int k, input int len);
    int cnt = 0;
    for (int i = 0; i < len; i++) begin
      if (m[i]) begin
        if (cnt == k) return i;
        cnt++;
      end
    end
    return len;
  endfunction

  function automatic int pop(input logic [63:0] m);
    int cnt = 0;
    for (int i = 0; i < 64; i++) cnt += int'(m[i]);
    return cnt;
  endfunction

  // rdy_mode: 0 always ready, 1 pseudo-random, 2 stalled for three samples
  task automatic run_case(input int v, input int mode, input bit tw, input bit si, input bit di,
                          input logic [63:0] sr, input logic [63:0] dr,
                          input logic [63:0] sc, input logic [63:0] dc,
                          input int rdy_mode, input bit poke, input string tag);
    int lim, np, n, done_at, ps, pd;
    bit stall;
    logic [63:0] sm, dm;
    lim = (v > 64) ? 64 : v;
    sm  = model_mask(mode, si, tw ? sr : dr, tw ? sc : dc, lim);
    dm  = model_mask(mode, di, dr, dc, lim);
    np  = (pop(sm) < pop(dm)) ? pop(sm) : pop(dm);
    @(negedge clk);
    vl = VW'(v); pmode = 2'(mode); twin = tw; sinv = si; dinv = di;
    sreg = sr; dreg = dr; scond = sc; dcond = dc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; stall = 1'b0; done_at = -1; ps = 0; pd = 0;
    for (int c = 0; c < 400; c++) begin
      if (stall)
        check(out_valid && int'(src_step) == ps && int'(dst_step) == pd,
              {tag, " R10 stalled pair held"}, int'(src_step), ps);
      if (done) begin
        done_at = c;
        break;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rdy_mode == 0)      out_ready = 1'b1;
      else if (rdy_mode == 1) out_ready = lfsr[0] | lfsr[3];
      else                    out_ready = (c >= 3);
      if (poke && c == 1) begin
        start = 1'b1;
        vl = 7'd1;
      end else begin
        start = 1'b0;
      end
      if (out_valid && out_ready) begin
        check(n < np, {tag, " R8 no extra pair"}, n + 1, np);
        if (n < np) begin
          check(int'(src_step) == kth(sm, n, lim), {tag, " R2 source index"},
                int'(src_step), kth(sm, n, lim));
          check(int'(dst_step) == kth(dm, n, lim), {tag, " R3 destination index"},
                int'(dst_step), kth(dm, n, lim));
        end
        n++;
      end
      stall = out_valid && !out_ready;
      ps = int'(src_step);
      pd = int'(dst_step);
      @(negedge clk);
    end
    start = 1'b0;
    check(done_at >= 0, {tag, " R8 done reached"}, done_at, 0);
    check(n == np, {tag, " R8 pair count"}, n, np);
    check(int'(src_step) == kth(sm, np, lim), {tag, " R11 final source counter"},
          int'(src_step), kth(sm, np, lim));
    check(int'(dst_step) == kth(dm, np, lim), {tag, " R11 final destination counter"},
          int'(dst_step), kth(dm, np, lim));
    if (np == 0) check(done_at == 1, {tag, " R9 empty finish latency"}, done_at, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !out_valid, "R1 flags after reset",
          int'({busy, done, out_valid}), 0);
    check(src_step == '0 && dst_step == '0, "R1 counters after reset",
          int'(src_step) + int'(dst_step), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !out_valid, "R1 flags idle after release",
          int'({busy, done, out_valid}), 0);

    // R6: worked example, one pair (0,1)
    run_case(2, 1, 1'b1, 1'b1, 1'b0, 64'b10, 64'b10, 64'h0, 64'h0, 0, 1'b0, "R6 example");

    // R2 R3 R6: exhaustive integer twin sweep with all inversion pairs
    for (int v = 0; v <= 4; v++)
      for (int s = 0; s < 16; s++)
        for (int d = 0; d < 16; d++)
          for (int iv = 0; iv < 4; iv++)
            run_case(v, 1, 1'b1, iv[0], iv[1], 64'(s), 64'(d), 64'hFFFF_0000_FFFF_0000,
                     64'h0, 1, 1'b0, "R2 R3 R6 int twin");

    // R4: single selector, source register must be ignored
    for (int v = 0; v <= 5; v++)
      for (int d = 0; d < 32; d++)
        for (int iv = 0; iv < 4; iv++)
          run_case(v, 1, 1'b0, iv[0], iv[1], 64'hDEAD_BEEF_0F0F_5A5A, 64'(d), 64'h0,
                   64'h0, 1, 1'b0, "R4 int single");

    // R5: condition bits, twin and single selector
    for (int v = 0; v <= 4; v++)
      for (int s = 0; s < 16; s++)
        for (int d = 0; d < 16; d++)
          run_case(v, 2, 1'b1, 1'b0, 1'b0, 64'h0, 64'hFFFF, 64'(s), 64'(d), 1, 1'b0,
                   "R5 cond twin");
    for (int d = 0; d < 32; d++)
      run_case(5, 2, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 64'h15, 64'(d), 1, 1'b0,
               "R5 cond single");

    // R7: all-ones modes ignore inversion
    for (int v = 0; v <= 9; v++) begin
      run_case(v, 0, 1'b1, 1'b1, 1'b1, 64'h0, 64'h0, 64'h0, 64'h0, 1, 1'b0, "R7 mode 00");
      run_case(v, 3, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 64'h0, 64'h0, 0, 1'b0, "R7 mode 11");
    end

    // R13: length clamp
    run_case(100, 0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h0, 64'h0, 0, 1'b0, "R13 clamp 100");
    run_case(64, 1, 1'b1, 1'b0, 1'b1, 64'hAAAA_5555_F0F0_0001, 64'h1234_0000_0000_0000,
             64'h0, 64'h0, 1, 1'b0, "R13 full width");

    // R12: start during a stalled run is ignored
    run_case(6, 0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h0, 64'h0, 2, 1'b1, "R12 start while busy");
    run_case(7, 1, 1'b1, 1'b0, 1'b0, 64'h6D, 64'h5B, 64'h0, 64'h0, 2, 1'b1, "R12 masked busy");

    // R8: done persists until the next start
    @(negedge clk);
    @(negedge clk);
    check(done && !busy, "R8 done held", int'(done), 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule